// File: doc/BRIEF.md
# Byte-Writable Pipelined Synchronous SRAM

This block is a single-clock synchronous static RAM with a 32-bit word made of four 8-bit lanes. On each rising clock edge it takes in the address, the write data and every control input. From these it decides whether the cycle is a deselect, a read or a write. A write can change all four lanes through the global write input. It can also change any chosen subset of lanes through the byte-write path, which has one active-low strobe per lane and an active-low byte-write enable that gates them.

A write stores the captured data into the array one edge after capture. No outside pulse timing is involved. A read is pipelined: the array word goes into an output register at the edge after capture, and an output enable marks that a valid read word is on the output. The shared data bus is split into an input port, an output port and that output enable. The chip is selected only when all three chip enables are asserted, so several instances can share one bus and give a deeper memory. The address sequence, including any burst order, is supplied from outside. The depth is a parameter.

Top module: `pipe_sram32`

## Requirements
- R1: A selected read cycle captures its address at clock edge E. At edge E+1, dataOut holds the stored word at that address and dataOe is 1. Reads issued back to back come out one per cycle, in the order they were issued.
- R2: With the chip selected and gwN = 0, the cycle writes all four lanes of the addressed word from dataIn. This holds whatever the values of bweN and bwN.
- R3: With the chip selected, gwN = 1 and bweN = 0, each lane i whose bwN[i] = 0 is written from dataIn. Lane i is bits [8i+7:8i], so lane a is bits 7:0 and lane d is bits 31:24. Lanes whose bwN[i] = 1 keep their old contents.
- R4: A selected cycle is a read when no lane is to be written. This happens when gwN = 1 and either bweN = 1 or all bwN bits are 1. In that case the byte strobes change no stored data.
- R5: The chip is selected only when ce1N = 0, ce2 = 1 and ce3N = 0. Any other combination is a deselect cycle. A deselect cycle writes nothing and leaves dataOe at 0 at the following edge.
- R6: After a write cycle captured at edge E, dataOe is 0 from edge E+1. After any cycle that is not a read, dataOut keeps the last word that was read.
- R7: While rstN is low, dataOe and dataOut are 0.
- R8: A write at edge E followed by a read of the same address at edge E+1 returns the newly written word at edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control and output state |
| addr | input | ADDR_W | Word address, captured each edge |
| dataIn | input | 32 | Write data, captured each edge |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| gwN | input | 1 | Global write of all lanes, active low |
| bweN | input | 1 | Enables the per-lane strobes, active low |
| bwN | input | 4 | Per-lane write strobes, active low, bit i for lane i |
| dataOut | output | 32 | Registered read data |
| dataOe | output | 1 | High when dataOut carries a word read in the previous cycle |

## Verification
Two things can happen in the same cycle. One is a global write while the byte-write path also asks for a partial lane set. The other is a write completing in the array at the same edge that a read of that address is being captured. Every global write in the address sweep is issued with bweN low and a partial, address-dependent strobe pattern, and the read-back must show all four lanes replaced. A write followed at once by a read of the same address must return the new word two edges after the write.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Strobes the control half hands to the datapath half each cycle.
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [LANES-1:0] laneWe;
  } sramStrobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  output sramStrobe_t      strobe,
  output logic             dataOe
);

  logic             selQ;
  logic             gwQ;
  logic             bweQ;
  logic [LANES-1:0] bwQ;
  logic [LANES-1:0] byteMask;
  logic [LANES-1:0] writeMask;
  logic             anyWrite;
  logic             oeQ;
  logic             selIn;

  assign selIn = !ce1N && ce2 && !ce3N;

  // Capture stage: every control input is registered, converted to active high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= 1'b0;
      gwQ  <= 1'b0;
      bweQ <= 1'b0;
      bwQ  <= '0;
    end else begin
      selQ <= selIn;
      gwQ  <= !gwN;
      bweQ <= !bweN;
      bwQ  <= ~bwN;
    end
  end

  // Lane decode: the global path overrides the per-lane path.
  assign byteMask  = bweQ ? bwQ : '0;
  assign writeMask = gwQ ? {LANES{1'b1}} : byteMask;
  assign anyWrite  = |writeMask;

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = selQ && anyWrite;
    strobe.rdEn   = selQ && !anyWrite;
    strobe.laneWe = (selQ && anyWrite) ? writeMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeQ <= 1'b0;
    else       oeQ <= strobe.rdEn;
  end

  assign dataOe = oeQ;

  // R5
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selIn |=> !strobe.wrEn && !strobe.rdEn);

  // R2
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && !gwN) |=> strobe.wrEn && (strobe.laneWe == {LANES{1'b1}}));

  // R4
  no_lane_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && gwN && (bweN || (&bwN))) |=> strobe.rdEn && (strobe.laneWe == '0));

  // R1
  read_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> dataOe);

  // R6
  write_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !dataOe);

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] mergedWord;
  logic [WORD_W-1:0] outQ;

  // Address and data need no reset: they are only consumed under a strobe.
  always_ff @(posedge clk) begin
    addrQ <= addr;
    dataQ <= dataIn;
  end

  assign curWord = mem[addrQ];

  // One lane multiplexer per byte lane.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] =
      strobe.laneWe[g] ? dataQ[g*LANE_W +: LANE_W] : curWord[g*LANE_W +: LANE_W];

    // R3
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && !strobe.laneWe[g]) |=>
        mem[$past(addrQ)][g*LANE_W +: LANE_W] == $past(curWord[g*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[addrQ] <= mergedWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outQ <= '0;
    else if (strobe.rdEn) outQ <= curWord;
  end

  assign dataOut = outQ;

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(dataOut));

  // R1
  read_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> dataOut == $past(curWord));

  // R2
  write_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && (&strobe.laneWe)) |=> mem[$past(addrQ)] == $past(dataQ));

endmodule

// File: rtl/pipe_sram32.sv
module pipe_sram32
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       dataIn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [3:0]        bwN,
  output logic [31:0]       dataOut,
  output logic              dataOe
);

  sramStrobe_t strobe;

  sram_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ce1N   (ce1N),
    .ce2    (ce2),
    .ce3N   (ce3N),
    .gwN    (gwN),
    .bweN   (bweN),
    .bwN    (bwN),
    .strobe (strobe),
    .dataOe (dataOe)
  );

  sram_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> !dataOe && (dataOut == '0));

endmodule

// File: tb/pipe_sram32_test.sv
`timescale 1ns/1ps
module pipe_sram32_test;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   dataIn = '0;
  logic          ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic          gwN = 1'b1, bweN = 1'b1;
  logic [3:0]    bwN = 4'hF;
  logic [31:0]   dataOut;
  logic          dataOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [N];
  logic [31:0] lastOut = '0;

  always #2 clk = ~clk;

  pipe_sram32 #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [31:0] pat(int a, int salt);
    logic [31:0] x;
    x = 32'(a + 1) * 32'h9E3779B1;
    return x ^ (32'(salt) * 32'h01010101);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change just after a falling edge and are captured at the next rising edge.
  task automatic op(logic c1n, logic c2, logic c3n, logic gw, logic bwe,
                    logic [3:0] bw, logic [AW-1:0] a, logic [31:0] d);
    ce1N = c1n; ce2 = c2; ce3N = c3n;
    gwN = gw; bweN = bwe; bwN = bw; addr = a; dataIn = d;
    @(negedge clk);
  endtask

  task automatic idle();
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, '0, 32'hDEAD_BEEF);
  endtask

  task automatic rd(logic [AW-1:0] a);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, a, 32'h5555_AAAA);
  endtask

  task automatic readCheck(string req, int a);
    rd(a[AW-1:0]);
    idle();
    chk({req, " oe"}, {31'b0, dataOe}, 32'd1);
    chk({req, " data"}, dataOut, model[a]);
    lastOut = model[a];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R7: outputs quiet during reset
    chk("R7 oe", {31'b0, dataOe}, 32'd0);
    chk("R7 data", dataOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: global writes with the byte path also asking for a partial lane set
    for (int a = 0; a < N; a++) begin
      logic [3:0] part;
      part = 4'(a) | 4'h1;
      op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, part, a[AW-1:0], pat(a, 0));
      model[a] = pat(a, 0);
      idle();
      if (a % 8 == 0) begin
        // R6: no output enable after a write, output keeps last read word
        chk("R6 oe after write", {31'b0, dataOe}, 32'd0);
        chk("R6 hold after write", dataOut, lastOut);
      end
    end
    for (int a = 0; a < N; a++) readCheck("R2", a);

    // R3/R4: every strobe pattern with the byte-write enable low
    for (int a = 0; a < N; a++) begin
      logic [3:0]  bw;
      logic [31:0] d;
      bw = 4'(a) ^ 4'(a >> 4);
      d  = pat(a, 7);
      op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, bw, a[AW-1:0], d);
      idle();
      if (bw == 4'hF) begin
        // R4: all strobes high is a read
        chk("R4 oe", {31'b0, dataOe}, 32'd1);
        chk("R4 data", dataOut, model[a]);
        lastOut = model[a];
      end else begin
        chk("R6 oe", {31'b0, dataOe}, 32'd0);
        for (int i = 0; i < 4; i++)
          if (!bw[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
      end
      readCheck("R3", a);
    end

    // R4: strobes ignored while byte-write enable is high
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd3, 32'h0BAD_F00D);
    idle();
    chk("R4 oe bwe high", {31'b0, dataOe}, 32'd1);
    chk("R4 data bwe high", dataOut, model[3]);
    lastOut = model[3];
    readCheck("R4", 3);

    // R5: every deselecting combination of the three enables
    for (int cs = 0; cs < 8; cs++) begin
      logic c1n, c2, c3n;
      c1n = cs[0]; c2 = cs[1]; c3n = cs[2];
      if (!c1n && c2 && !c3n) continue;
      op(c1n, c2, c3n, 1'b0, 1'b0, 4'h0, 6'd5, pat(cs, 99));
      idle();
      chk("R5 oe desel write", {31'b0, dataOe}, 32'd0);
      chk("R5 hold desel", dataOut, lastOut);
      op(c1n, c2, c3n, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
      idle();
      chk("R5 oe desel read", {31'b0, dataOe}, 32'd0);
      readCheck("R5", 5);
    end

    // R8: write then immediate read of the same address
    op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd9, 32'hC0FF_EE11);
    model[9] = 32'hC0FF_EE11;
    rd(6'd9);
    idle();
    chk("R8 oe", {31'b0, dataOe}, 32'd1);
    chk("R8 data", dataOut, 32'hC0FF_EE11);

    // R8: byte write then immediate read
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 6'd9, 32'h1122_3344);
    model[9][7:0]   = 8'h44;
    model[9][23:16] = 8'h22;
    rd(6'd9);
    idle();
    chk("R8 byte data", dataOut, model[9]);

    // R1: back-to-back reads emerge one per cycle
    rd(6'd10);
    rd(6'd20);
    chk("R1 first oe", {31'b0, dataOe}, 32'd1);
    chk("R1 first data", dataOut, model[10]);
    rd(6'd30);
    chk("R1 second data", dataOut, model[20]);
    idle();
    chk("R1 third data", dataOut, model[30]);
    idle();
    chk("R1 oe drops", {31'b0, dataOe}, 32'd0);
    lastOut = model[30];

    // R7: reset mid-run clears the outputs
    rd(6'd10);
    rstN = 1'b0;
    @(negedge clk);
    chk("R7 oe again", {31'b0, dataOe}, 32'd0);
    chk("R7 data again", dataOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule